// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit linear address into a 32-bit physical address. It reads two entries from a table structure in memory: first a directory entry, then a second-level table entry. A requester presents a linear address together with the value of the directory base register. Each memory access is a single 32-bit read issued over a valid/ready request port, and its data comes back later on a separate response port. When the walk finishes, the walker returns either the translated address or a fault with a reason code, and then it is ready for the next request.

The linear address has three fields. Bits 31:22 index the directory, bits 21:12 index the second-level table, and bits 11:0 are the byte offset within a 4 KiB page. Every entry is 32 bits wide. Its upper 20 bits hold a 4 KiB-aligned base, and its low 12 bits hold attribute flags. Bit 0 of those flags marks the entry as present. Only one walk is in progress at a time.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, `mem_req_valid` is 0 and `res_done` is 0.
- R2: A request is taken only on a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low from acceptance until the result has been delivered, and a request held during a walk has no effect on that walk.
- R3: The first read goes to address {dir_base[31:12], lin[31:22], 2'b00}. The low 12 bits of the directory base are ignored.
- R4: Once `mem_req_valid` is raised, it stays high with a stable `mem_req_addr` until the cycle in which `mem_req_ready` is high.
- R5: When the directory entry has bit 0 set, the second read goes to address {dir_entry[31:12], lin[21:12], 2'b00}.
- R6: When both entries have bit 0 set, the result is `res_phys_addr` = {table_entry[31:12], lin[11:0]} with `res_fault` = 0 and `res_fault_code` = 0. Entry bits 11:1 have no effect on the result.
- R7: When the directory entry has bit 0 clear, the walk ends with `res_fault` = 1 and `res_fault_code` = 1, and no second read is issued. `res_phys_addr` is 0.
- R8: When the table entry has bit 0 clear, the walk ends with `res_fault` = 1 and `res_fault_code` = 2. `res_phys_addr` is 0.
- R9: `res_done` is high for exactly one cycle per walk. In the following cycle `req_ready` is 1 again.
- R10: A `mem_rsp_valid` pulse that arrives while no read is waiting for its data is ignored. This covers the idle state and the cycles in which a read request is still waiting for ready.
- R11: The walker tolerates any number of cycles of delay before `mem_req_ready` and before `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_lin_addr | input | 32 | Linear address to translate |
| req_dir_base | input | 32 | Directory base register value |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid pulse |
| mem_rsp_data | input | 32 | Read data |
| res_done | output | 1 | One-cycle result strobe |
| res_phys_addr | output | 32 | Translated physical address |
| res_fault | output | 1 | Walk ended in a fault |
| res_fault_code | output | 2 | 0 none, 1 directory entry absent, 2 table entry absent |

## Verification
The hardest situation to create is a response pulse that arrives while a read request is still waiting for ready. If the walker wrongly took that pulse as data, it would end the walk with a fault. To reach this case, the bench holds `mem_req_ready` low for several cycles on both reads. During those cycles it pulses `mem_rsp_valid` with a word whose present bit is clear, and it sends one more stray pulse while the walker is idle. A second hard case is a competing request held high for the whole length of a walk with a different address. The bench drives this one and then checks that both the read addresses and the result still belong to the first request.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin_addr,
  input  logic [31:0] req_dir_base,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        res_done,
  output logic [31:0] res_phys_addr,
  output logic        res_fault,
  output logic [1:0]  res_fault_code
);
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int ADDR_W  = 2 * IDX_W + OFF_W;
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int PRESENT = 0;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH_DIR, S_WAIT_DIR, S_FETCH_TBL, S_WAIT_TBL, S_DONE
  } st_t;

  st_t                st;
  logic [ADDR_W-1:0]  lin_q;
  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] tbl_q;
  logic [ADDR_W-1:0]  res_q;
  logic [1:0]         code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      lin_q  <= '0;
      base_q <= '0;
      tbl_q  <= '0;
      res_q  <= '0;
      code_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          lin_q  <= req_lin_addr;
          base_q <= req_dir_base[ADDR_W-1:OFF_W];
          code_q <= '0;
          res_q  <= '0;
          st     <= S_FETCH_DIR;
        end
        S_FETCH_DIR: if (mem_req_ready) st <= S_WAIT_DIR;
        S_WAIT_DIR: if (mem_rsp_valid) begin
          tbl_q <= mem_rsp_data[ADDR_W-1:OFF_W];
          if (!mem_rsp_data[PRESENT]) begin
            code_q <= 2'd1;
            res_q  <= '0;
            st     <= S_DONE;
          end else begin
            st <= S_FETCH_TBL;
          end
        end
        S_FETCH_TBL: if (mem_req_ready) st <= S_WAIT_TBL;
        S_WAIT_TBL: if (mem_rsp_valid) begin
          if (!mem_rsp_data[PRESENT]) begin
            code_q <= 2'd2;
            res_q  <= '0;
          end else begin
            code_q <= 2'd0;
            res_q  <= {mem_rsp_data[ADDR_W-1:OFF_W], lin_q[OFF_W-1:0]};
          end
          st <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready      = (st == S_IDLE);
  assign mem_req_valid  = (st == S_FETCH_DIR) || (st == S_FETCH_TBL);
  assign mem_req_addr   = (st == S_FETCH_TBL)
                        ? {tbl_q,  lin_q[OFF_W+IDX_W-1:OFF_W], 2'b00}
                        : {base_q, lin_q[ADDR_W-1:OFF_W+IDX_W], 2'b00};
  assign res_done       = (st == S_DONE);
  assign res_phys_addr  = res_q;
  assign res_fault      = (code_q != 2'd0);
  assign res_fault_code = code_q;

  // R4
  r4_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R9
  r9_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_done |=> !res_done && req_ready);

  // R2
  r2_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> $stable(lin_q));

  // R7
  r7_no_tbl_chk: assert property (@(posedge clk) disable iff (rst)
    res_done && res_fault_code == 2'd1 |-> $past(st) == S_WAIT_DIR);

  // R6
  r6_offset_chk: assert property (@(posedge clk) disable iff (rst)
    res_done && !res_fault |-> res_phys_addr[OFF_W-1:0] == lin_q[OFF_W-1:0]);

  // R8
  r8_code_chk: assert property (@(posedge clk) disable iff (rst)
    res_done |-> (res_fault == (res_fault_code != 2'd0)) && res_fault_code != 2'd3);
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin_addr = '0;
  logic [31:0] req_dir_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_done;
  logic [31:0] res_phys_addr;
  logic        res_fault;
  logic [1:0]  res_fault_code;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] mem [logic [31:0]];

  pt_walker dut (.*);

  initial forever #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errs = errs + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_walk(input string tag, input logic [31:0] lin, input logic [31:0] base,
                          input int rdly, input int lat, input bit stray, input bit busy);
    logic [31:0] da, ta, pde, pte, exp_pa, a0, got_pa;
    logic [1:0]  exp_code, got_code;
    logic        got_fault;
    logic [31:0] rd_addr [2];
    int exp_reads, rd_cnt, wcnt, n;
    bit done, hold_bad, busy_bad;
    da  = {base[31:12], lin[31:22], 2'b00};
    pde = rd(da);
    ta  = {pde[31:12], lin[21:12], 2'b00};
    pte = rd(ta);
    if (!pde[0]) begin exp_code = 2'd1; exp_pa = 0; exp_reads = 1; end
    else if (!pte[0]) begin exp_code = 2'd2; exp_pa = 0; exp_reads = 2; end
    else begin exp_code = 2'd0; exp_pa = {pte[31:12], lin[11:0]}; exp_reads = 2; end
    rd_cnt = 0; wcnt = 0; n = 0; done = 0; hold_bad = 0; busy_bad = 0;
    rd_addr[0] = 0; rd_addr[1] = 0; a0 = 0; got_pa = 0; got_code = 0; got_fault = 0;

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (stray) begin
      mem_rsp_valid = 1; mem_rsp_data = 32'hFFFF_F000;
      @(negedge clk);
      mem_rsp_valid = 0;
    end
    req_valid = 1; req_lin_addr = lin; req_dir_base = base;
    @(negedge clk);
    if (busy) begin
      req_lin_addr = lin ^ 32'h0040_3000;
      req_dir_base = base ^ 32'h0000_1000;
    end else req_valid = 0;

    while (!done && n < 400) begin
      n++;
      mem_rsp_valid = 0;
      if (busy && req_ready && !res_done) busy_bad = 1;
      if (res_done) begin
        done = 1; got_pa = res_phys_addr; got_code = res_fault_code; got_fault = res_fault;
        req_valid = 0;
      end else if (mem_req_valid) begin
        if (wcnt == 0) a0 = mem_req_addr;
        else if (mem_req_addr != a0) hold_bad = 1;
        if (wcnt < rdly) begin
          wcnt++;
          mem_rsp_valid = stray; mem_rsp_data = 32'hFFFF_F000;
          @(negedge clk);
        end else begin
          mem_req_ready = 1;
          if (rd_cnt < 2) rd_addr[rd_cnt] = mem_req_addr;
          rd_cnt++; wcnt = 0;
          @(negedge clk);
          mem_req_ready = 0;
          repeat (lat) @(negedge clk);
          mem_rsp_valid = 1; mem_rsp_data = rd(rd_addr[rd_cnt > 2 ? 1 : rd_cnt-1]);
          @(negedge clk);
        end
      end else @(negedge clk);
    end
    mem_rsp_valid = 0;
    if (!done) check(0, {tag, " watchdog R9"}, 0, 1);
    check(rd_cnt == exp_reads, {tag, " read count R7"}, rd_cnt, exp_reads);
    check(rd_addr[0] == da, {tag, " directory address R3"}, rd_addr[0], da);
    if (exp_reads == 2) check(rd_addr[1] == ta, {tag, " table address R5"}, rd_addr[1], ta);
    check(got_code == exp_code, {tag, " fault code R6 R7 R8"}, got_code, exp_code);
    check(got_fault == (exp_code != 0), {tag, " fault flag R8"}, got_fault, exp_code != 0);
    check(got_pa == exp_pa, {tag, " physical address R6"}, got_pa, exp_pa);
    if (rdly > 0) check(!hold_bad, {tag, " request held R4"}, hold_bad, 0);
    if (busy) check(!busy_bad, {tag, " busy not ready R2"}, busy_bad, 0);
    @(negedge clk);
    check(!res_done && req_ready, {tag, " single pulse R9"}, {res_done, req_ready}, 2'b01);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_ready && !mem_req_valid && !res_done, "reset R1",
          {req_ready, mem_req_valid, res_done}, 3'b100);
    rst = 0;
    @(negedge clk);
    check(req_ready && !mem_req_valid && !res_done, "after reset R1",
          {req_ready, mem_req_valid, res_done}, 3'b100);
  endtask

  task automatic t_basic();
    mem[32'h0010_0000 | (32'h048 << 2)] = 32'h0020_0001;
    mem[32'h0020_0000 | (32'h345 << 2)] = 32'hABCD_E001;
    run_walk("basic R6", 32'h1234_5678, 32'h0010_0000, 0, 0, 0, 0);
  endtask

  task automatic t_latency();
    run_walk("latency R11", 32'h1234_5ABC, 32'h0010_0000, 3, 5, 0, 0);
  endtask

  task automatic t_attr();
    mem[32'h0030_0000 | (32'h3FF << 2)] = 32'h0040_0FFF;
    mem[32'h0040_0000 | (32'h3FF << 2)] = 32'h8765_4FFF;
    run_walk("attr R6", 32'hFFFF_FFFF, 32'h0030_0ABC, 1, 2, 0, 0);
  endtask

  task automatic t_dir_fault();
    mem[32'h0050_0000] = 32'h0060_0FFE;
    run_walk("dir fault R7", 32'h0000_0123, 32'h0050_0000, 2, 1, 0, 0);
  endtask

  task automatic t_tbl_fault();
    mem[32'h0050_0000 | (32'h001 << 2)] = 32'h0070_0003;
    mem[32'h0070_0000 | (32'h002 << 2)] = 32'h1111_1FFE;
    run_walk("tbl fault R8", 32'h0040_2777, 32'h0050_0000, 0, 4, 0, 0);
  endtask

  task automatic t_busy();
    run_walk("busy R2", 32'h1234_5678, 32'h0010_0000, 2, 3, 0, 1);
  endtask

  task automatic t_stray();
    run_walk("stray R10", 32'h1234_5678, 32'h0010_0000, 4, 1, 1, 0);
  endtask

  task automatic t_zero();
    mem[32'h0000_0000] = 32'h0001_0001;
    mem[32'h0001_0000] = 32'h0002_0001;
    run_walk("zero index R5", 32'h0000_0000, 32'h0000_0000, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_latency();
    t_attr();
    t_dir_fault();
    t_tbl_fault();
    t_busy();
    t_stray();
    t_zero();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule